// File: doc/BRIEF.md
# Serial Word EEPROM Device Model

This block is a synthesizable behavioural model of a small serial EEPROM built from 16-bit words. A host drives a chip select, a serial clock and a serial data input, and the model answers on one serial data output. The model works entirely in the system clock domain. It samples the serial clock, and each rising edge of the serial clock shifts in or shifts out exactly one bit.

Each transaction starts with a 1 bit while select is high. Next come a two-bit operation code and an address, sent most significant bit first. Write commands then carry a 16-bit data word. The model supports these operations:
- single-word read, write and erase;
- array-wide erase and write;
- enabling and disabling of programming.

A write-protect latch gates every operation that changes the array, and that latch is clear after reset. When a programming operation is accepted, the device enters a busy interval. While it is busy and selected in idle, the output is held low for a parameterised number of serial clock edges. After that the output goes high to show the device is ready.

Top module: `serial_word_eeprom`

## Requirements
- R1: While select is high and the device is idle, zero bits on the input are ignored. The first 1 bit sampled on a rising serial clock edge starts a command.
- R2: After the start bit come two opcode bits and then ADDR_BITS address bits, all most significant bit first. The opcodes are: 10 read, 01 write, 11 erase, 00 extended.
- R3: A read drives the output low during the cycle after the last address bit. On each of the next 16 rising edges it presents the word's next bit, bit 15 first. On the 17th edge the output returns low.
- R4: A write takes 16 data bits, most significant first, after the address. If programming is enabled, it stores them at the address.
- R5: An erase sets the addressed word to 0xFFFF when programming is enabled.
- R6: For opcode 00, the two most significant address bits select the extended command. 11 enables programming and 00 disables it. 10 sets every word to 0xFFFF. 01 takes 16 data bits and stores them in every word.
- R7: After reset, every word reads 0xFFFF and programming is disabled. While selected and idle, the output is high.
- R8: When programming is disabled, write, erase, erase-all and write-all leave the array unchanged and start no busy interval.
- R9: After an accepted programming command, select is dropped and raised again. The output then stays low for BUSY_CYCLES rising serial clock edges and goes high afterwards. A 1 bit sampled while busy starts no command.
- R10: Whenever select is low, the output is low. Dropping select abandons any partial command, so the array is unchanged and the next command decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, sampled by clk |
| di | input | 1 | Serial data into the device |
| dout | output | 1 | Serial data out: read bits, or ready (1) and busy (0) status |

## Verification
The assertions assume that cs, sck and di are synchronous to clk. They also assume that sck stays high and stays low for at least one clk cycle each, so that every rising edge is seen exactly once, and that cs never changes in the same cycle as a rising serial clock edge. The stimulus meets these assumptions by moving inputs only on the falling edge of clk. Data is set up one cycle before sck rises, sck is held high for two cycles and low for at least one, and each change of select is followed by a cycle with no edge.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_OPC   = 3'd1,
      PH_ADDR  = 3'd2,
      PH_DATA  = 3'd3,
      PH_RDOUT = 3'd4,
      PH_DONE  = 3'd5
   } phase_t;

   localparam logic [1:0] OPC_EXT   = 2'b00;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_ERASE = 2'b11;

   localparam logic [1:0] EXT_LOCK  = 2'b00;
   localparam logic [1:0] EXT_FILL  = 2'b01;
   localparam logic [1:0] EXT_CLEAR = 2'b10;
   localparam logic [1:0] EXT_OPEN  = 2'b11;

endpackage

// File: rtl/mwe_word_array.sv
module mwe_word_array #(
   parameter int ADDR_BITS = 6,
   parameter int DATA_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic                 we_all,
   input  logic [ADDR_BITS-1:0] wr_addr,
   input  logic [DATA_BITS-1:0] wr_data,
   input  logic [ADDR_BITS-1:0] rd_addr,
   output logic [DATA_BITS-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_BITS;

   logic [DATA_BITS-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic hit;
      assign hit = we && (we_all || (wr_addr == ADDR_BITS'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[i] <= '1;
         end else if (hit) begin
            words[i] <= wr_data;
         end
      end
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/mwe_busy_timer.sv
module mwe_busy_timer #(
   parameter int BUSY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy
);

   localparam int CW = $clog2(BUSY_CYCLES + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start) begin
         left_q <= CW'(BUSY_CYCLES);
      end else if (tick && (left_q != '0)) begin
         left_q <= left_q - CW'(1);
      end
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/mwe_decoder.sv
module mwe_decoder
   import mwe_pkg::*;
#(
   parameter int ADDR_BITS = 6,
   parameter int DATA_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs,
   input  logic                 sck_rise,
   input  logic                 di,
   input  logic                 busy,
   input  logic [DATA_BITS-1:0] rd_data,
   output phase_t               phase,
   output logic                 wr_enabled,
   output logic                 prog_go,
   output logic                 prog_all,
   output logic [ADDR_BITS-1:0] prog_addr,
   output logic [DATA_BITS-1:0] prog_data,
   output logic [ADDR_BITS-1:0] rd_addr,
   output logic                 rd_bit
);

   localparam int CNT_W = $clog2(DATA_BITS + 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);
   localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(DATA_BITS);

   phase_t               phase_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [1:0]           op_q;
   logic [ADDR_BITS-1:0] addr_q;
   logic [DATA_BITS-2:0] data_q;
   logic                 wen_q;

   logic [ADDR_BITS-1:0] addr_nx;
   logic [DATA_BITS-1:0] data_nx;
   logic [1:0]           sub_nx;

   assign addr_nx = {addr_q[ADDR_BITS-2:0], di};
   assign data_nx = {data_q, di};
   assign sub_nx  = addr_nx[ADDR_BITS-1 -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         op_q      <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         wen_q     <= 1'b0;
         prog_go   <= 1'b0;
         prog_all  <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         prog_go <= 1'b0;
         if (!cs) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
         end else if (sck_rise) begin
            case (phase_q)
               PH_IDLE: begin
                  if (!busy && di) begin
                     phase_q <= PH_OPC;
                     cnt_q   <= '0;
                  end
               end
               PH_OPC: begin
                  op_q <= {op_q[0], di};
                  if (cnt_q == CNT_W'(1)) begin
                     phase_q <= PH_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               PH_ADDR: begin
                  addr_q <= addr_nx;
                  if (cnt_q == ADDR_LAST) begin
                     cnt_q <= '0;
                     case (op_q)
                        OPC_READ:  phase_q <= PH_RDOUT;
                        OPC_WRITE: phase_q <= PH_DATA;
                        OPC_ERASE: begin
                           phase_q <= PH_DONE;
                           if (wen_q) begin
                              prog_go   <= 1'b1;
                              prog_all  <= 1'b0;
                              prog_addr <= addr_nx;
                              prog_data <= '1;
                           end
                        end
                        default: begin
                           case (sub_nx)
                              EXT_OPEN: begin
                                 wen_q   <= 1'b1;
                                 phase_q <= PH_DONE;
                              end
                              EXT_LOCK: begin
                                 wen_q   <= 1'b0;
                                 phase_q <= PH_DONE;
                              end
                              EXT_CLEAR: begin
                                 phase_q <= PH_DONE;
                                 if (wen_q) begin
                                    prog_go   <= 1'b1;
                                    prog_all  <= 1'b1;
                                    prog_data <= '1;
                                 end
                              end
                              default: phase_q <= PH_DATA;
                           endcase
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               PH_DATA: begin
                  data_q <= data_nx[DATA_BITS-2:0];
                  if (cnt_q == DATA_LAST) begin
                     phase_q <= PH_DONE;
                     cnt_q   <= '0;
                     if (wen_q) begin
                        prog_go   <= 1'b1;
                        prog_all  <= (op_q == OPC_EXT);
                        prog_addr <= addr_q;
                        prog_data <= data_nx;
                     end
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               PH_RDOUT: begin
                  if (cnt_q == RD_LAST) begin
                     phase_q <= PH_DONE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: phase_q <= PH_DONE;
            endcase
         end
      end
   end

   logic [DATA_BITS-1:0] rd_shift;

   always_comb begin
      rd_shift = rd_data << (cnt_q - CNT_W'(1));
      rd_bit   = (cnt_q != '0) && rd_shift[DATA_BITS-1];
   end

   assign phase      = phase_q;
   assign wr_enabled = wen_q;
   assign rd_addr    = addr_q;

endmodule

// File: rtl/serial_word_eeprom.sv
module serial_word_eeprom
   import mwe_pkg::*;
#(
   parameter int ADDR_BITS   = 6,
   parameter int DATA_BITS   = 16,
   parameter int BUSY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sck,
   input  logic di,
   output logic dout
);

   if ((ADDR_BITS != 6) && (ADDR_BITS != 8)) begin : g_bad_addr
      $error("serial_word_eeprom: ADDR_BITS must be 6 or 8");
   end
   if (DATA_BITS <= ADDR_BITS) begin : g_bad_data
      $error("serial_word_eeprom: DATA_BITS must exceed ADDR_BITS");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("serial_word_eeprom: BUSY_CYCLES must be at least 1");
   end

   logic                 sck_q;
   logic                 sck_rise;
   phase_t               phase;
   logic                 busy;
   logic                 wr_enabled;
   logic                 prog_go;
   logic                 prog_all;
   logic [ADDR_BITS-1:0] prog_addr;
   logic [DATA_BITS-1:0] prog_data;
   logic [ADDR_BITS-1:0] rd_addr;
   logic [DATA_BITS-1:0] rd_data;
   logic                 rd_bit;
   logic                 busy_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck;
   end

   assign sck_rise  = sck & ~sck_q;
   assign busy_tick = sck_rise & cs & (phase == PH_IDLE);

   mwe_decoder #(
      .ADDR_BITS (ADDR_BITS),
      .DATA_BITS (DATA_BITS)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .sck_rise   (sck_rise),
      .di         (di),
      .busy       (busy),
      .rd_data    (rd_data),
      .phase      (phase),
      .wr_enabled (wr_enabled),
      .prog_go    (prog_go),
      .prog_all   (prog_all),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .rd_addr    (rd_addr),
      .rd_bit     (rd_bit)
   );

   mwe_word_array #(
      .ADDR_BITS (ADDR_BITS),
      .DATA_BITS (DATA_BITS)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (prog_go),
      .we_all  (prog_all),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   mwe_busy_timer #(
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (prog_go),
      .tick  (busy_tick),
      .busy  (busy)
   );

   assign dout = cs & (((phase == PH_RDOUT) & rd_bit) | ((phase == PH_IDLE) & ~busy));

endmodule

// File: rtl/mwe_checker.sv
module mwe_checker
   import mwe_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   cs,
   input logic   dout,
   input logic   busy,
   input logic   wr_enabled,
   input phase_t phase
);

   a_r10_dout_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !dout);

   a_r10_idle_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> (phase == PH_IDLE));

   a_r9_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && busy) |-> !dout);

   a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (phase == PH_IDLE)) |=> (phase == PH_IDLE));

   a_r8_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_enabled));

   a_r6_enable_from_command: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_enabled) |-> ($past(phase) == PH_ADDR));

endmodule

bind serial_word_eeprom mwe_checker u_mwe_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs         (cs),
   .dout       (dout),
   .busy       (busy),
   .wr_enabled (wr_enabled),
   .phase      (phase)
);

// File: tb/serial_word_eeprom_bench.sv
module serial_word_eeprom_bench;

   localparam int CLK_P = 10;
   localparam int AW    = 6;
   localparam int DW    = 16;
   localparam int BUSY  = 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sck = 1'b0;
   logic di = 1'b0;
   logic dout;

   int n_vec = 0;
   int n_bad = 0;
   bit running = 1'b0;
   bit finished = 1'b0;
   string cur_req = "R7";

   always #(CLK_P/2) clk = ~clk;

   serial_word_eeprom #(
      .ADDR_BITS   (AW),
      .DATA_BITS   (DW),
      .BUSY_CYCLES (BUSY)
   ) u_serial_word_eeprom (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs),
      .sck   (sck),
      .di    (di),
      .dout  (dout)
   );

   // reference model: 0 idle, 1 collecting, 2 reading, 3 finished
   logic [15:0] m_mem [DEPTH];
   bit          m_wen;
   bit          m_cs;
   int          m_mode;
   int          m_busy;
   int          m_k;
   int          m_addr;
   int          m_op;
   logic [15:0] m_rd;
   bit          m_q[$];

   function automatic bit exp_dout();
      if (!m_cs) return 1'b0;
      if (m_mode == 0) return (m_busy == 0);
      if (m_mode == 2) return (m_k == 0) ? 1'b0 : m_rd[16 - m_k];
      return 1'b0;
   endfunction

   task automatic m_program(input int a, input logic [15:0] d, input bit all);
      if (m_wen) begin
         if (all) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = d;
         end else begin
            m_mem[a] = d;
         end
         m_busy = BUSY;
      end
   endtask

   task automatic m_rise(input bit b);
      int n;
      int top;
      logic [15:0] d;
      case (m_mode)
         0: begin
            if (m_busy > 0) m_busy--;
            else if (b) begin
               m_mode = 1;
               m_q.delete();
            end
         end
         1: begin
            m_q.push_back(b);
            n = m_q.size();
            if (n == 2 + AW) begin
               m_op = m_q[0] * 2 + m_q[1];
               m_addr = 0;
               for (int i = 0; i < AW; i++) m_addr = m_addr * 2 + m_q[2 + i];
               top = m_q[2] * 2 + m_q[3];
               if (m_op == 2) begin
                  m_mode = 2; m_k = 0; m_rd = m_mem[m_addr];
               end else if (m_op == 3) begin
                  m_program(m_addr, 16'hFFFF, 1'b0); m_mode = 3;
               end else if (m_op == 0) begin
                  if (top == 3) begin m_wen = 1'b1; m_mode = 3; end
                  else if (top == 0) begin m_wen = 1'b0; m_mode = 3; end
                  else if (top == 2) begin m_program(0, 16'hFFFF, 1'b1); m_mode = 3; end
               end
            end else if (n == 2 + AW + 16) begin
               d = '0;
               for (int i = 0; i < 16; i++) d = {d[14:0], m_q[2 + AW + i]};
               m_program(m_addr, d, m_op == 0);
               m_mode = 3;
            end
         end
         2: begin
            if (m_k == 16) m_mode = 3;
            else m_k++;
         end
         default: ;
      endcase
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #(CLK_P/4);
      if (running) begin
         check(dout === exp_dout(), cur_req, dout, exp_dout(), "per-clock dout");
      end
   end

   task automatic set_cs(input bit v);
      @(negedge clk);
      cs = v; sck = 1'b0; m_cs = v;
      if (!v) m_mode = 0;
      @(negedge clk);
   endtask

   task automatic sbit(input bit b);
      @(negedge clk);
      di = b;
      @(negedge clk);
      sck = 1'b1;
      if (m_cs) m_rise(b);
      @(negedge clk);
      @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic send_val(input int v, input int n);
      for (int i = n - 1; i >= 0; i--) sbit(bit'((v >> i) & 1));
   endtask

   task automatic cmd(input int op, input int a, input bit has_data, input int d);
      set_cs(1'b1);
      sbit(1'b1);
      send_val(op, 2);
      send_val(a, AW);
      if (has_data) send_val(d, 16);
      set_cs(1'b0);
   endtask

   task automatic ext(input int sub, input bit has_data, input int d);
      cmd(0, sub << (AW - 2), has_data, d);
   endtask

   task automatic do_read(input int a, output logic [15:0] w, output bit dummy, output bit tail);
      set_cs(1'b1);
      sbit(1'b1);
      send_val(2, 2);
      send_val(a, AW);
      dummy = dout;
      w = '0;
      for (int i = 0; i < 16; i++) begin
         sbit(1'b0);
         w = {w[14:0], dout};
      end
      sbit(1'b0);
      tail = dout;
      set_cs(1'b0);
   endtask

   task automatic read_expect(input int a, input logic [15:0] exp, input string req);
      logic [15:0] w;
      bit dm, tl;
      do_read(a, w, dm, tl);
      check(w === exp, req, w, exp, $sformatf("word at %0d", a));
      check(dm == 1'b0, "R3", dm, 0, "dummy bit before data");
      check(tl == 1'b0, "R3", tl, 0, "output after last data bit");
   endtask

   task automatic busy_poll(output int n, output bit first);
      set_cs(1'b1);
      first = dout;
      n = 0;
      while (dout == 1'b0 && n < 200) begin
         sbit(1'b0);
         n++;
      end
      set_cs(1'b0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int n;
      bit first;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
      m_wen = 0; m_cs = 0; m_mode = 0; m_busy = 0; m_k = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);

      // R7: reset state
      cur_req = "R7";
      check(dout == 1'b0, "R7", dout, 0, "output while deselected after reset");
      set_cs(1'b1);
      check(dout == 1'b1, "R7", dout, 1, "ready while idle after reset");
      set_cs(1'b0);
      read_expect(5, 16'hFFFF, "R7");

      // R8: write while protected
      cur_req = "R8";
      cmd(1, 3, 1'b1, 16'h1234);
      busy_poll(n, first);
      check(n == 0, "R8", n, 0, "busy edges after protected write");
      read_expect(3, 16'hFFFF, "R8");
      cmd(3, 9, 1'b0, 0);
      busy_poll(n, first);
      check(n == 0, "R8", n, 0, "busy edges after protected erase");

      // R6 enable, R4 write, R9 busy
      cur_req = "R6";
      ext(3, 1'b0, 0);
      cur_req = "R4";
      cmd(1, 3, 1'b1, 16'hA5C3);
      cur_req = "R9";
      busy_poll(n, first);
      check(first == 1'b0, "R9", first, 0, "output on reselect while busy");
      check(n == BUSY, "R9", n, BUSY, "busy length in serial edges");
      cur_req = "R4";
      read_expect(3, 16'hA5C3, "R4");

      // R2: address ordering at the extremes
      cur_req = "R2";
      cmd(1, 0, 1'b1, 16'h0001);
      busy_poll(n, first);
      cmd(1, DEPTH - 1, 1'b1, 16'h8000);
      busy_poll(n, first);
      read_expect(0, 16'h0001, "R2");
      read_expect(DEPTH - 1, 16'h8000, "R2");
      read_expect(3, 16'hA5C3, "R2");

      // R5: erase
      cur_req = "R5";
      cmd(3, 3, 1'b0, 0);
      busy_poll(n, first);
      check(n == BUSY, "R5", n, BUSY, "busy after erase");
      read_expect(3, 16'hFFFF, "R5");

      // R6: write-all and erase-all
      cur_req = "R6";
      ext(1, 1'b1, 16'h5A5A);
      busy_poll(n, first);
      read_expect(0, 16'h5A5A, "R6");
      read_expect(40, 16'h5A5A, "R6");
      ext(2, 1'b0, 0);
      busy_poll(n, first);
      check(n == BUSY, "R6", n, BUSY, "busy after erase-all");
      read_expect(7, 16'hFFFF, "R6");
      cmd(1, 12, 1'b1, 16'h0F0F);
      busy_poll(n, first);

      // R6/R8: disable then try to program
      ext(0, 1'b0, 0);
      cur_req = "R8";
      cmd(1, 10, 1'b1, 16'h0000);
      busy_poll(n, first);
      check(n == 0, "R8", n, 0, "no busy after write while disabled");
      ext(1, 1'b1, 16'h0000);
      ext(2, 1'b0, 0);
      read_expect(10, 16'hFFFF, "R8");
      read_expect(12, 16'h0F0F, "R8");

      // R10: abandoned command
      cur_req = "R10";
      ext(3, 1'b0, 0);
      set_cs(1'b1);
      sbit(1'b1);
      send_val(1, 2);
      send_val(5, 3);
      set_cs(1'b0);
      check(dout == 1'b0, "R10", dout, 0, "output while deselected");
      read_expect(20, 16'hFFFF, "R10");

      // R1: leading zeros before start
      cur_req = "R1";
      set_cs(1'b1);
      sbit(1'b0); sbit(1'b0); sbit(1'b0);
      check(dout == 1'b1, "R1", dout, 1, "still idle after zero bits");
      sbit(1'b1);
      send_val(1, 2);
      send_val(21, AW);
      send_val(16'hC001, 16);
      set_cs(1'b0);
      busy_poll(n, first);
      read_expect(21, 16'hC001, "R1");

      // R9: ones during busy start nothing
      cur_req = "R9";
      cmd(1, 22, 1'b1, 16'h7777);
      set_cs(1'b1);
      for (int i = 0; i < BUSY; i++) sbit(1'b1);
      check(dout == 1'b1, "R9", dout, 1, "ready after ones while busy");
      set_cs(1'b0);
      read_expect(22, 16'h7777, "R9");

      running = 1'b0;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule